// File: doc/BRIEF.md
# Unsigned Bitfield Insert-Zero Unit

This combinational execute unit takes a 32-bit instruction word and a 64-bit source operand. It confirms that the word is an unsigned bitfield-move instruction and decodes four fields from it: the size flag, the N flag, the rotate immediate (`immr`) and the mask-end immediate (`imms`). The field position and width are not given directly. The unit recovers them from the two immediates.

When `imms` is numerically below `immr`, the word is the insert-in-zeros form. The lowest `imms+1` bits of the source are placed at bit `(size - immr) mod size`, and every other result bit is cleared. For any other legal immediate pair, the unit produces the general extract result. That result is source bits `imms` down to `immr`, zero-extended into the low end.

The unit also passes through the register indices. It reports whether the word is legal, and whether insert-in-zeros is the preferred way to print the instruction. Register file access and pipelining belong to the surrounding stages.

Top module: `ubfiz_unit`

## Requirements
- R1: Bits 30:23 of the word must equal 8'b10100110. Any other value raises `illegal` and clears `valid`.
- R2: The size flag (bit 31) and N (bit 22) must match. A mismatch raises `illegal`.
- R3: In the 32-bit form (bit 31 = 0), bit 21 (`immr[5]`) or bit 15 (`imms[5]`) set raises `illegal`.
- R4: `valid` is the inverse of `illegal`. While `illegal` is high, `result` is all zero and `insert_pref` is low.
- R5: For a legal word with `imms < immr`, `result` is the low `imms+1` source bits shifted up to bit `p = size - immr`. Every other bit is zero.
- R6: `insert_pref` is high exactly when the word is legal and `imms < immr`, where `immr` is bits 21:16 and `imms` is bits 15:10.
- R7: For a legal word with `imms >= immr`, `result` holds source bits `imms..immr` at bits `imms-immr..0`. All higher bits are zero.
- R8: In the 32-bit form, only source bits 31:0 affect the result, and result bits 63:32 are zero.
- R9: `dst_idx` always equals word bits 4:0, and `src_idx` always equals word bits 9:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| src_data | input | 64 | Source operand value |
| result | output | 64 | Placed or extracted bitfield |
| dst_idx | output | 5 | Destination register index |
| src_idx | output | 5 | Source register index |
| valid | output | 1 | Word is a legal encoding of this class |
| illegal | output | 1 | Word fails the class or size checks |
| insert_pref | output | 1 | Insert-in-zeros is the preferred form |

## Verification
The unit holds no state, so a wrong decode shows at the ports as soon as the inputs settle. Each failure has a distinct signature:
- A wrong position shows as field bits shifted by the error.
- A wrong width shows as a field that stops short or runs long.
- A lost size check shows as leftover bits above bit 31, or as a missing `illegal`.

The bench sweeps every legal position and width pair in both sizes, then sweeps every extract pair. Each result is compared with a shift-and-mask model, so any misplaced or extra bit is caught on that vector.

// File: rtl/ubfiz_pkg.sv
package ubfiz_pkg;

    localparam int INSN_W = 32;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int IMM_W  = $clog2(DATA_W);
    localparam int SPAN_W = IMM_W + 2;
    localparam int IDX_W  = 5;

    // Expected value of word bits 30:23 for this instruction class
    localparam logic [7:0] CLASS_BITS = 8'b1010_0110;

    typedef enum logic {
        MODE_EXTRACT = 1'b0,
        MODE_INSERT  = 1'b1
    } ubf_mode_e;

    typedef struct packed {
        logic             wide;
        logic             illegal;
        logic [IMM_W-1:0] rot;
        logic [IMM_W-1:0] top;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
    } ubf_fields_t;

endpackage

// File: rtl/ubfiz_decode.sv
module ubfiz_decode
    import ubfiz_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output ubf_fields_t       fields_o
);

    logic size_bit;
    logic n_bit;
    logic class_ok;
    logic size_ok;
    logic narrow_ok;

    always_comb begin
        size_bit  = word_i[31];
        n_bit     = word_i[22];
        class_ok  = (word_i[30:23] == CLASS_BITS);
        size_ok   = (size_bit == n_bit);
        narrow_ok = size_bit || !(word_i[21] || word_i[15]);

        fields_o.wide    = size_bit;
        fields_o.illegal = !(class_ok && size_ok && narrow_ok);
        fields_o.rot     = word_i[21:16];
        fields_o.top     = word_i[15:10];
        fields_o.rn      = word_i[9:5];
        fields_o.rd      = word_i[4:0];
    end

endmodule

// File: rtl/ubfiz_span.sv
module ubfiz_span
    import ubfiz_pkg::*;
(
    input  logic              wide_i,
    input  logic [IMM_W-1:0]  rot_i,
    input  logic [IMM_W-1:0]  top_i,
    output ubf_mode_e         mode_o,
    output logic [SPAN_W-1:0] shamt_o,
    output logic [SPAN_W-1:0] lo_o,
    output logic [SPAN_W-1:0] hi_o
);

    logic [SPAN_W-1:0] size_w;
    logic [SPAN_W-1:0] rot_w;
    logic [SPAN_W-1:0] top_w;
    logic [SPAN_W-1:0] place;

    always_comb begin
        size_w = wide_i ? SPAN_W'(DATA_W) : SPAN_W'(HALF_W);
        rot_w  = SPAN_W'(rot_i);
        top_w  = SPAN_W'(top_i);
        // Position recovered from the rotate amount; rot is non-zero here
        place  = size_w - rot_w;

        unique case (top_w < rot_w)
            1'b1: begin
                mode_o  = MODE_INSERT;
                shamt_o = place;
                lo_o    = place;
                hi_o    = place + top_w;
            end
            default: begin
                mode_o  = MODE_EXTRACT;
                shamt_o = rot_w;
                lo_o    = '0;
                hi_o    = top_w - rot_w;
            end
        endcase
    end

endmodule

// File: rtl/ubfiz_place.sv
module ubfiz_place
    import ubfiz_pkg::*;
(
    input  logic              wide_i,
    input  ubf_mode_e         mode_i,
    input  logic [SPAN_W-1:0] shamt_i,
    input  logic [SPAN_W-1:0] lo_i,
    input  logic [SPAN_W-1:0] hi_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] field_o
);

    logic [DATA_W-1:0] src_sized;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] keep;

    always_comb begin
        src_sized = wide_i ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
        unique case (mode_i)
            MODE_INSERT:  moved = src_sized << shamt_i;
            default:      moved = src_sized >> shamt_i;
        endcase
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_keep
        assign keep[b] = (SPAN_W'(b) >= lo_i) && (SPAN_W'(b) <= hi_i);
    end

    assign field_o = moved & keep;

endmodule

// File: rtl/ubfiz_unit.sv
module ubfiz_unit
    import ubfiz_pkg::*;
(
    input  logic [INSN_W-1:0] instr_word,
    input  logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] result,
    output logic [IDX_W-1:0]  dst_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic              valid,
    output logic              illegal,
    output logic              insert_pref
);

    ubf_fields_t       fields;
    ubf_mode_e         mode;
    logic [SPAN_W-1:0] shamt;
    logic [SPAN_W-1:0] lo_bit;
    logic [SPAN_W-1:0] hi_bit;
    logic [DATA_W-1:0] field;

    ubfiz_decode u_decode (
        .word_i   (instr_word),
        .fields_o (fields)
    );

    ubfiz_span u_span (
        .wide_i  (fields.wide),
        .rot_i   (fields.rot),
        .top_i   (fields.top),
        .mode_o  (mode),
        .shamt_o (shamt),
        .lo_o    (lo_bit),
        .hi_o    (hi_bit)
    );

    ubfiz_place u_place (
        .wide_i  (fields.wide),
        .mode_i  (mode),
        .shamt_i (shamt),
        .lo_i    (lo_bit),
        .hi_i    (hi_bit),
        .src_i   (src_data),
        .field_o (field)
    );

    always_comb begin
        illegal     = fields.illegal;
        valid       = !fields.illegal;
        result      = fields.illegal ? '0 : field;
        insert_pref = !fields.illegal && (mode == MODE_INSERT);
        dst_idx     = fields.rd;
        src_idx     = fields.rn;
    end

endmodule

// File: rtl/ubfiz_unit_chk.sv
module ubfiz_unit_chk
    import ubfiz_pkg::*;
(
    input logic [INSN_W-1:0] instr_word,
    input logic [DATA_W-1:0] result,
    input logic              valid,
    input logic              illegal,
    input logic              insert_pref
);

    logic              known;
    logic [SPAN_W-1:0] place;
    logic [DATA_W-1:0] below;

    always_comb begin
        known = !$isunknown(instr_word);
        place = (instr_word[31] ? SPAN_W'(DATA_W) : SPAN_W'(HALF_W))
                - SPAN_W'(instr_word[21:16]);
        below = (DATA_W'(1) << place[IMM_W-1:0]) - DATA_W'(1);

        if (known) begin
            a_r2_size_mismatch: assert (instr_word[31] == instr_word[22] || illegal)
                else $error("size mismatch accepted");
            a_r4_illegal_zero: assert (!illegal || (result == '0 && !valid))
                else $error("illegal word left data or valid");
            a_r6_pref_legal: assert (!insert_pref || valid)
                else $error("preferred flag on illegal word");
            a_r8_upper_clear: assert (instr_word[31] || result[DATA_W-1:HALF_W] == '0)
                else $error("upper half set in narrow form");
            a_r5_below_clear: assert (!insert_pref || (result & below) == '0)
                else $error("bits below inserted field set");
        end
    end

endmodule

bind ubfiz_unit ubfiz_unit_chk u_chk (
    .instr_word  (instr_word),
    .result      (result),
    .valid       (valid),
    .illegal     (illegal),
    .insert_pref (insert_pref)
);

// File: tb/sim_ubfiz_unit.sv
module sim_ubfiz_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic [63:0] src_data = '0;
    logic [63:0] result;
    logic [4:0]  dst_idx;
    logic [4:0]  src_idx;
    logic        valid;
    logic        illegal;
    logic        insert_pref;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ubfiz_unit u0 (
        .instr_word  (instr_word),
        .src_data    (src_data),
        .result      (result),
        .dst_idx     (dst_idx),
        .src_idx     (src_idx),
        .valid       (valid),
        .illegal     (illegal),
        .insert_pref (insert_pref)
    );

    function automatic logic [63:0] lowmask(int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [31:0] mk(bit sf, bit n, int rot, int top, int rn, int rd);
        return {sf, 2'b10, 6'b100110, n, 6'(rot), 6'(top), 5'(rn), 5'(rd)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h word=%h src=%h",
                     req, act, exp, instr_word, src_data);
        end
    endtask

    task automatic apply(logic [31:0] w, logic [63:0] s);
        @(negedge clk);
        instr_word = w;
        src_data   = s;
        #1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R4: all-zero word is not of this class
        apply(32'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 reset-word illegal", {63'd0, illegal}, 64'd1);
        chk("R4 reset-word valid", {63'd0, valid}, 64'd0);
        chk("R4 reset-word result", result, 64'd0);

        // R5 R6 R8: every legal position/width pair, both sizes
        for (int sz = 32; sz <= 64; sz += 32) begin
            for (int p = 0; p < sz; p++) begin
                for (int w = 1; w <= sz - p; w++) begin
                    logic [63:0] s;
                    logic [63:0] exp;
                    int rot;
                    s   = 64'h9E37_79B9_7F4A_7C15 * 64'(p * 67 + w + 1);
                    rot = (sz - p) % sz;
                    exp = ((s & lowmask(w)) << p) & lowmask(sz);
                    apply(mk(sz == 64, sz == 64, rot, w - 1, (p + w) % 32, p % 32), s);
                    chk(p == 0 ? "R7 insert-at-zero result" : "R5 R8 insert result",
                        result, exp);
                    chk("R6 preferred flag", {63'd0, insert_pref}, {63'd0, (w - 1) < rot});
                end
            end
        end

        // R7 R8: every extract pair, both sizes
        for (int sz = 32; sz <= 64; sz += 32) begin
            for (int r = 0; r < sz; r++) begin
                for (int t = r; t < sz; t++) begin
                    logic [63:0] s;
                    logic [63:0] exp;
                    s   = ~(64'hC2B2_AE3D_27D4_EB4F * 64'(r * 131 + t + 7));
                    exp = ((s & lowmask(sz)) >> r) & lowmask(t - r + 1);
                    apply(mk(sz == 64, sz == 64, r, t, 3, 9), s);
                    chk("R7 R8 extract result", result, exp);
                    chk("R6 extract not preferred", {63'd0, insert_pref}, 64'd0);
                end
            end
        end

        // R9: index pass-through
        for (int i = 0; i < 32; i++) begin
            apply(mk(1'b1, 1'b1, 5, 2, i, 31 - i), 64'h1234);
            chk("R9 dst_idx", {59'd0, dst_idx}, 64'(31 - i));
            chk("R9 src_idx", {59'd0, src_idx}, 64'(i));
        end

        // R1: any single flipped class bit
        for (int b = 23; b <= 30; b++) begin
            logic [31:0] w;
            w = mk(1'b1, 1'b1, 60, 3, 1, 2);
            w[b] = ~w[b];
            apply(w, '1);
            chk("R1 class bit illegal", {63'd0, illegal}, 64'd1);
            chk("R1 class bit valid", {63'd0, valid}, 64'd0);
            chk("R4 class bit result", result, 64'd0);
        end

        // R2: size and N disagree
        apply(mk(1'b1, 1'b0, 60, 3, 1, 2), '1);
        chk("R2 sf1 n0 illegal", {63'd0, illegal}, 64'd1);
        chk("R4 sf1 n0 pref", {63'd0, insert_pref}, 64'd0);
        apply(mk(1'b0, 1'b1, 30, 3, 1, 2), '1);
        chk("R2 sf0 n1 illegal", {63'd0, illegal}, 64'd1);
        chk("R4 sf0 n1 result", result, 64'd0);

        // R3: bit 5 of an immediate in the narrow form
        apply(mk(1'b0, 1'b0, 32, 3, 1, 2), '1);
        chk("R3 immr bit5 illegal", {63'd0, illegal}, 64'd1);
        apply(mk(1'b0, 1'b0, 4, 40, 1, 2), '1);
        chk("R3 imms bit5 illegal", {63'd0, illegal}, 64'd1);
        apply(mk(1'b1, 1'b1, 32, 40, 1, 2), '1);
        chk("R3 wide form accepts bit5", {63'd0, valid}, 64'd1);

        // R8: upper source half ignored in narrow form
        apply(mk(1'b0, 1'b0, 0, 31, 0, 0), 64'hFFFF_FFFF_0000_0001);
        chk("R8 narrow ignores upper source", result, 64'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule